// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit is the buffering and flag core of an SPI controller. It holds a transmit queue and a receive queue, each 16 words of 32 bits by default. It also computes the status flags that software polls or takes interrupts on. Software pushes transmit words with a bus write to the transmit data address and pops received words with a bus read from the receive data address. The serial shift engine sits on the other side: it pulls transmit words, pushes received words and signals the end of a transfer with a one-cycle pulse.

There are eight status flags. Six of them follow the fill levels directly. Two are sticky: receive overflow and transfer complete. Each sticky flag stays set until software writes a one to its bit. An enable register with the same bit layout masks the flags into a single interrupt line. A test register shows both fill counts. A control write flushes both queues and clears every sticky flag.

The bus is a simple strobe interface with a 3-bit word address. Read data is combinational from the current state. A read strobe on the receive data address pops the word that is being shown in that same cycle.

Top module: `spi_fifo_status`

## Requirements
- R1: After reset the status register (address 3) reads 0x01, the test register (address 4) reads 0, the enable register (address 2) reads 0 and `irq` is low.
- R2: Status bits are computed from the counts as follows:
  - bit 0 is set when the transmit count is 0.
  - bit 1 is set when the transmit count is at least 8.
  - bit 2 is set when the transmit count is 16.
  - bit 3 is set when the receive count is nonzero.
  - bit 4 is set when the receive count is at least 8.
  - bit 5 is set when the receive count is 16.
  - Bits 31:8 read 0.
- R3: A bus write to address 1 appends `bus_wdata` to the transmit queue. When the queue already holds 16 words, the write is ignored.
- R4: `eng_tx_data` shows the oldest transmit word, and `eng_tx_pop` removes it. The engine therefore receives words in the order they were written. When the transmit queue is empty, `eng_tx_data` is 0 and `eng_tx_pop` changes nothing.
- R5: `eng_rx_push` appends `eng_rx_data` to the receive queue. A bus read at address 0 returns the oldest receive word and, with `bus_rd` high, removes it. When the receive queue is empty, the read returns 0 and changes nothing.
- R6: An `eng_rx_push` while the receive queue holds 16 words discards the word and sets sticky status bit 6. Writing address 3 with bit 6 set clears that flag. Writing 0 to bit 6, or writing any of bits 5:0, has no effect.
- R7: An `eng_done` pulse sets sticky status bit 7. Writing address 3 with bit 7 set clears it. If a set and a clear happen in the same cycle, the set wins.
- R8: The test register (address 4) shows the transmit count in bits 4:0 and the receive count in bits 9:5. All other bits read 0.
- R9: The enable register (address 2) is read/write in bits 7:0. `irq` is high exactly when some status bit and the matching enable bit are both 1.
- R10: A write to address 5 with bit 0 set empties both queues and clears status bits 6 and 7 by the next cycle. The enable register is kept. This flush takes priority over any push in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops at address 0) |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| eng_tx_pop | input | 1 | Shift engine takes the oldest transmit word |
| eng_tx_data | output | 32 | Oldest transmit word, 0 when empty |
| eng_rx_push | input | 1 | Shift engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| eng_done | input | 1 | Transfer-complete pulse |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check the following on every cycle:
- Neither count exceeds the depth.
- A full transmit queue is not grown by a write.
- An empty transmit queue presents zero.
- A push into a full receive queue raises the overflow flag.
- The completion flag stays set until it is cleared.
- A flush leaves both queues empty with both sticky flags clear.
- The interrupt stays low while nothing is enabled.

Other behaviours can only be shown by the bench scenarios. These are the word ordering through each queue, the exact flag pattern at every fill level from 0 to 16, the interaction between write-one-to-clear and a simultaneous set, and the interrupt result under all 256 enable masks.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

   localparam int ADDR_W = 3;
   localparam int NFLAG  = 8;

   typedef enum logic [ADDR_W-1:0] {
      A_RXDATA = 3'd0,
      A_TXDATA = 3'd1,
      A_INTEN  = 3'd2,
      A_STATUS = 3'd3,
      A_TEST   = 3'd4,
      A_CTRL   = 3'd5
   } sfs_addr_e;

   // status / enable bit positions
   localparam int F_TX_EMPTY = 0;
   localparam int F_TX_HALF  = 1;
   localparam int F_TX_FULL  = 2;
   localparam int F_RX_READY = 3;
   localparam int F_RX_HALF  = 4;
   localparam int F_RX_FULL  = 5;
   localparam int F_RX_OVF   = 6;
   localparam int F_DONE     = 7;

endpackage

// File: rtl/sfs_fifo.sv
module sfs_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic                          push,
   input  logic [DATA_W-1:0]             push_data,
   input  logic                          pop,
   output logic [DATA_W-1:0]             head,
   output logic [$clog2(DEPTH+1)-1:0]    count
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sfs_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic              push_ok, pop_ok;

   assign push_ok = push && (count != CW'(DEPTH));
   assign pop_ok  = pop  && (count != '0);
   assign head    = (count == '0) ? '0 : mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok && !flush) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/sfs_flags.sv
module sfs_flags
   import sfs_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int HALF_MARK = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic [$clog2(DEPTH+1)-1:0]    tx_cnt,
   input  logic [$clog2(DEPTH+1)-1:0]    rx_cnt,
   input  logic                          rx_drop,
   input  logic                          done_evt,
   input  logic [NFLAG-1:0]              clr_mask,
   output logic [NFLAG-1:0]              status
);
   localparam int CW = $clog2(DEPTH+1);

   if (HALF_MARK < 1 || HALF_MARK > DEPTH) begin : g_bad_half
      $error("sfs_flags: HALF_MARK out of range");
   end

   logic ovf_q, done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (flush) begin
         ovf_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (rx_drop)                 ovf_q <= 1'b1;
         else if (clr_mask[F_RX_OVF]) ovf_q <= 1'b0;
         if (done_evt)                done_q <= 1'b1;
         else if (clr_mask[F_DONE])   done_q <= 1'b0;
      end
   end

   always_comb begin
      status             = '0;
      status[F_TX_EMPTY] = (tx_cnt == '0);
      status[F_TX_HALF]  = (tx_cnt >= CW'(HALF_MARK));
      status[F_TX_FULL]  = (tx_cnt == CW'(DEPTH));
      status[F_RX_READY] = (rx_cnt != '0);
      status[F_RX_HALF]  = (rx_cnt >= CW'(HALF_MARK));
      status[F_RX_FULL]  = (rx_cnt == CW'(DEPTH));
      status[F_RX_OVF]   = ovf_q;
      status[F_DONE]     = done_q;
   end

endmodule

// File: rtl/spi_fifo_status.sv
module spi_fifo_status
   import sfs_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int DEPTH     = 16,
   parameter int HALF_MARK = DEPTH / 2,
   parameter bit REG_IRQ   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              eng_tx_pop,
   output logic [DATA_W-1:0] eng_tx_data,
   input  logic              eng_rx_push,
   input  logic [DATA_W-1:0] eng_rx_data,
   input  logic              eng_done,
   output logic              irq
);
   localparam int CW = $clog2(DEPTH+1);

   if (DATA_W < 2*CW || DATA_W < NFLAG) begin : g_bad_width
      $error("spi_fifo_status: DATA_W too small for status or test fields");
   end

   logic [CW-1:0]    tx_cnt, rx_cnt;
   logic [DATA_W-1:0] rx_head;
   logic [NFLAG-1:0] status, int_en, clr_mask, pend;
   logic             tx_push, rx_pop, flush_req, rx_drop;

   assign tx_push   = bus_wr && (bus_addr == A_TXDATA);
   assign rx_pop    = bus_rd && (bus_addr == A_RXDATA);
   assign flush_req = bus_wr && (bus_addr == A_CTRL) && bus_wdata[0];
   assign clr_mask  = (bus_wr && (bus_addr == A_STATUS)) ? bus_wdata[NFLAG-1:0] : '0;
   assign rx_drop   = eng_rx_push && (rx_cnt == CW'(DEPTH)) && !flush_req;

   sfs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(flush_req),
      .push(tx_push), .push_data(bus_wdata), .pop(eng_tx_pop),
      .head(eng_tx_data), .count(tx_cnt)
   );

   sfs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(flush_req),
      .push(eng_rx_push), .push_data(eng_rx_data), .pop(rx_pop),
      .head(rx_head), .count(rx_cnt)
   );

   sfs_flags #(.DEPTH(DEPTH), .HALF_MARK(HALF_MARK)) u_flags (
      .clk(clk), .rst_n(rst_n), .flush(flush_req),
      .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .rx_drop(rx_drop),
      .done_evt(eng_done), .clr_mask(clr_mask), .status(status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  int_en <= '0;
      else if (bus_wr && (bus_addr == A_INTEN))    int_en <= bus_wdata[NFLAG-1:0];
   end

   for (genvar i = 0; i < NFLAG; i++) begin : g_pend
      assign pend[i] = status[i] & int_en[i];
   end

   if (REG_IRQ) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= |pend;
      end
   end else begin : g_irq_comb
      assign irq = |pend;
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_RXDATA: bus_rdata = rx_head;
         A_INTEN:  bus_rdata[NFLAG-1:0] = int_en;
         A_STATUS: bus_rdata[NFLAG-1:0] = status;
         A_TEST: begin
            bus_rdata[CW-1:0]    = tx_cnt;
            bus_rdata[2*CW-1:CW] = rx_cnt;
         end
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
   parameter int DEPTH = 16,
   parameter int CW    = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic [CW-1:0] tx_cnt,
   input logic [CW-1:0] rx_cnt,
   input logic [7:0]    status,
   input logic [7:0]    int_en,
   input logic          irq,
   input logic          flush_req,
   input logic          eng_tx_pop,
   input logic          eng_rx_push,
   input logic          eng_done,
   input logic [7:0]    clr_mask,
   input logic [31:0]   eng_tx_data
);

   p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

   p_tx_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt == CW'(DEPTH)) && !eng_tx_pop && !flush_req |=> tx_cnt == CW'(DEPTH));

   p_tx_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt == '0) |-> (eng_tx_data == '0));

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt == CW'(DEPTH)) && eng_rx_push && !flush_req |=> status[6]);

   p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done && !flush_req |=> status[7]);

   p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      status[7] && !flush_req && !clr_mask[7] |=> status[7]);

   p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |=> (tx_cnt == '0) && (rx_cnt == '0) && (status[7:6] == 2'b00));

   p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (int_en == '0) && ($past(int_en) == '0) |-> !irq);

endmodule

bind spi_fifo_status sfs_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
   .status(status), .int_en(int_en), .irq(irq), .flush_req(flush_req),
   .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push), .eng_done(eng_done),
   .clr_mask(clr_mask), .eng_tx_data(eng_tx_data[31:0])
);

// File: tb/spi_fifo_status_bench.sv
module spi_fifo_status_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        eng_tx_pop = 1'b0;
   logic [31:0] eng_tx_data;
   logic        eng_rx_push = 1'b0;
   logic [31:0] eng_rx_data = '0;
   logic        eng_done = 1'b0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   logic [31:0] v;

   always #4 clk = ~clk;

   spi_fifo_status u_spi_fifo_status (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
      .eng_done(eng_done), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      step();
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic peek(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic rx_read(output logic [31:0] d);
      bus_addr = 3'd0; bus_rd = 1'b1;
      #1;
      d = bus_rdata;
      step();
      bus_rd = 1'b0;
   endtask

   task automatic eng_push(input logic [31:0] d);
      eng_rx_push = 1'b1; eng_rx_data = d;
      step();
      eng_rx_push = 1'b0;
   endtask

   task automatic eng_pop(output logic [31:0] d);
      eng_tx_pop = 1'b1;
      #1;
      d = eng_tx_data;
      step();
      eng_tx_pop = 1'b0;
   endtask

   function automatic logic [31:0] exp_stat(int t, int r, bit o, bit dn);
      logic [31:0] s = '0;
      s[0] = (t == 0);  s[1] = (t >= 8);  s[2] = (t == 16);
      s[3] = (r != 0);  s[4] = (r >= 8);  s[5] = (r == 16);
      s[6] = o;         s[7] = dn;
      return s;
   endfunction

   function automatic logic [31:0] exp_test(int t, int r);
      return 32'(t) | (32'(r) << 5);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int tcnt, rcnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      peek(3'd3, v); chk("R1 status", v, 32'h01);
      peek(3'd4, v); chk("R1 test", v, 0);
      peek(3'd2, v); chk("R1 enable", v, 0);
      chk("R1 irq", {31'b0, irq}, 0);

      // R3 R2 R8 transmit fill sweep including two ignored writes
      for (int i = 0; i < 18; i++) begin
         wr(3'd1, 32'hA500_0000 + 32'(i));
         tcnt = (i + 1 > 16) ? 16 : i + 1;
         peek(3'd3, v); chk("R2 tx flags", v, exp_stat(tcnt, 0, 0, 0));
         peek(3'd4, v); chk("R8 R3 tx count", v, exp_test(tcnt, 0));
      end
      // R4 order and empty pop
      for (int i = 0; i < 17; i++) begin
         eng_pop(v);
         chk("R4 tx order", v, (i < 16) ? 32'hA500_0000 + 32'(i) : 32'h0);
         tcnt = (16 - i - 1 < 0) ? 0 : 16 - i - 1;
         peek(3'd4, v); chk("R4 tx count", v, exp_test(tcnt, 0));
      end

      // R5 R6 receive fill sweep with overflow
      for (int i = 0; i < 18; i++) begin
         eng_push(32'hC300_0000 + 32'(i));
         rcnt = (i + 1 > 16) ? 16 : i + 1;
         peek(3'd3, v); chk("R6 R2 rx flags", v, exp_stat(0, rcnt, i >= 16, 0));
         peek(3'd4, v); chk("R8 rx count", v, exp_test(0, rcnt));
      end
      wr(3'd3, 32'h3F);
      peek(3'd3, v); chk("R6 no-effect clear", v, exp_stat(0, 16, 1, 0));
      wr(3'd3, 32'h40);
      peek(3'd3, v); chk("R6 overflow cleared", v, exp_stat(0, 16, 0, 0));
      for (int i = 0; i < 17; i++) begin
         rx_read(v);
         chk("R5 rx order", v, (i < 16) ? 32'hC300_0000 + 32'(i) : 32'h0);
         rcnt = (16 - i - 1 < 0) ? 0 : 16 - i - 1;
         peek(3'd4, v); chk("R5 rx count", v, exp_test(0, rcnt));
      end

      // R7 done sticky, clear, set-wins
      eng_done = 1'b1; step(); eng_done = 1'b0;
      step();
      peek(3'd3, v); chk("R7 done set", v, exp_stat(0, 0, 0, 1));
      wr(3'd3, 32'h80);
      peek(3'd3, v); chk("R7 done cleared", v, exp_stat(0, 0, 0, 0));
      eng_done = 1'b1; wr(3'd3, 32'h80); eng_done = 1'b0;
      peek(3'd3, v); chk("R7 set wins", v, exp_stat(0, 0, 0, 1));

      // R9 all enable masks, status 0x81
      for (int m = 0; m < 256; m++) begin
         wr(3'd2, 32'(m));
         peek(3'd2, v); chk("R9 enable readback", v, 32'(m));
         chk("R9 irq a", {31'b0, irq}, {31'b0, |(8'(m) & 8'h81)});
      end
      for (int i = 0; i < 9; i++) wr(3'd1, 32'h5A00_0000 + 32'(i));
      for (int m = 0; m < 256; m++) begin
         wr(3'd2, 32'(m));
         chk("R9 irq b", {31'b0, irq}, {31'b0, |(8'(m) & 8'h82)});
      end

      // R10 flush with a simultaneous receive push
      for (int i = 0; i < 17; i++) eng_push(32'h1111_0000 + 32'(i));
      peek(3'd3, v); chk("R10 pre-flush", v, exp_stat(9, 16, 1, 1));
      wr(3'd2, 32'h44);
      eng_rx_push = 1'b1; wr(3'd5, 32'h1); eng_rx_push = 1'b0;
      peek(3'd3, v); chk("R10 status", v, 32'h01);
      peek(3'd4, v); chk("R10 counts", v, 0);
      peek(3'd2, v); chk("R10 enable kept", v, 32'h44);
      eng_pop(v); chk("R10 tx empty data", v, 0);
      rx_read(v); chk("R10 rx empty data", v, 0);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule